// File: doc/BRIEF.md
# Burst Bus-Master Sequencer

This block is the bus-master side of a DMA engine. When its client raises a pending request, it asks for the system bus. Once the arbiter grants the bus, it runs back-to-back memory transfers from a base address, with the address stepping up by one unit per transfer. Each transfer either reads memory or writes it. After a run of transfers it hands the bus back, and it then stays off the bus for at least one cycle before it asks again.

A run of transfers, called a tenure, ends for one of three reasons: the client has nothing left to move, a programmable beat limit has been reached, or an active-low release input has been pulled low. In each of these cases the transfer in flight completes before the bus is released. If memory fails to acknowledge within 256 clocks, the tenure is cut off at once and a sticky memory-error flag is raised. In 16-bit mode the two bytes of a word can be exchanged on their way to or from memory. A data-buffer transfer and a control-structure transfer each have their own exchange setting.

Top module: `dma_burst_master`

## Requirements
- R1: `mem_strobe` never rises unless `bus_grant` was high in the previous cycle. `bus_req` is high for the whole of a tenure.
- R2: After an acknowledged transfer, the controller ends the tenure if `xfer_pending` is low in the following cycle. `bus_req` then falls one cycle later.
- R3: The beat limit is set by `cfg_limit`. With `cfg_wide`=1, the value 0 allows 1 transfer per tenure and 1 allows 8. With `cfg_wide`=0, the value 0 allows 2 transfers and 1 allows 16. The values 2 and 3 set no limit.
- R4: If `rel_n` is low while a transfer is acknowledged, that transfer completes. `mem_strobe` is low in the next cycle and `bus_req` is low one cycle after that.
- R5: If `mem_strobe` has been high for 256 cycles with no `mem_ack`, then in the next cycle `bus_req` and `mem_strobe` are low and `mem_err` is high.
- R6: `mem_err` stays high until `err_clr` is sampled high in a cycle with no new timeout. A new timeout takes priority over the clear.
- R7: After `bus_req` falls, it stays low for at least one more cycle.
- R8: Write data flows through `wr_data`→`mem_wdata` and read data through `mem_rdata`→`rd_data`. When `cfg_wide`=1, bits [15:8] and [7:0] are exchanged if the active selector is 1. That selector is `cfg_swap_ctrl` for a tenure started with `xfer_ctrl`=1 and `cfg_swap_data` otherwise. When `cfg_wide`=0, data passes through unchanged.
- R9: The first transfer of a tenure uses the `base_addr` value sampled at the grant. Each acknowledged transfer adds 2 to the address when `cfg_wide`=1 and 1 when it is 0.
- R10: During reset, `bus_req`, `mem_strobe`, `mem_err`, `wr_take` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_pending | input | 1 | Client has at least one transfer waiting |
| xfer_dir | input | 1 | 1 = write memory, 0 = read memory (sampled at grant) |
| xfer_ctrl | input | 1 | 1 = control-structure traffic, 0 = data buffer (sampled at grant) |
| base_addr | input | 16 | Start address of the tenure |
| wr_data | input | 16 | Write data from the client |
| cfg_wide | input | 1 | 1 = 16-bit transfers, 0 = 8-bit transfers |
| cfg_limit | input | 2 | Beat-limit selector |
| cfg_swap_data | input | 1 | Byte exchange for data-buffer traffic |
| cfg_swap_ctrl | input | 1 | Byte exchange for control-structure traffic |
| err_clr | input | 1 | Write-one clear of the memory-error flag |
| bus_grant | input | 1 | Bus granted by the arbiter |
| rel_n | input | 1 | Active-low request to give up the bus |
| mem_ack | input | 1 | Memory completes the current transfer |
| mem_rdata | input | 16 | Read data from memory |
| bus_req | output | 1 | Bus ownership request |
| mem_strobe | output | 1 | Address/data strobe for the transfer in flight |
| mem_we | output | 1 | Write enable qualifying the strobe |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 16 | Write data to memory |
| wr_take | output | 1 | Pops one write word from the client |
| rd_valid | output | 1 | `rd_data` holds an accepted read word |
| rd_data | output | 16 | Read data to the client |
| mem_err | output | 1 | Sticky memory-timeout flag |

## Verification
The properties take for granted that the arbiter keeps `bus_grant` high for as long as `bus_req` stays high. They also assume the configuration inputs do not change during a tenure, and that `mem_ack` is only asserted alongside the strobe. The bench's arbiter model drives the grant from `bus_req` after a random delay of 0 to 2 cycles, and drops it together with the request. It changes the configuration only between tenures, when the bus is idle. The memory model acknowledges after a random wait of 0 to 3 cycles, except in the timeout case, where it never answers.

// File: rtl/dma_burst_pkg.sv
// Package: shared state encoding and beat-limit selector values for the
// burst bus-master. Assumes nothing beyond being compiled first.
package dma_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // off the bus, waiting for work
        ST_REQ,    // bus requested, waiting for grant
        ST_XFER,   // strobe out, waiting for acknowledge
        ST_NEXT,   // decide whether the tenure continues
        ST_GAP     // bus released, mandatory idle cycle
    } bst_t;

    localparam logic [1:0] LIM_SMALL = 2'd0;
    localparam logic [1:0] LIM_MED   = 2'd1;
endpackage

// File: rtl/dma_beat_limiter.sv
// Counts acknowledged beats in a tenure and flags when the selected limit
// is reached. Byte mode scales the word limits by BYTES_PER_WORD.
// Assumes limit_sel and wide are stable during a tenure.
module dma_beat_limiter #(
    parameter int WORD_SMALL     = 1,
    parameter int WORD_MED       = 8,
    parameter int BYTES_PER_WORD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       beat,
    input  logic       wide,
    input  logic [1:0] limit_sel,
    output logic       limit_hit
);
    import dma_burst_pkg::*;

    localparam int MAX_BEATS = WORD_MED * BYTES_PER_WORD;
    localparam int CNT_W     = $clog2(MAX_BEATS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_v;

    // Select the beat count that ends the tenure.
    always_comb begin
        case (limit_sel)
            LIM_SMALL: limit_v = wide ? CNT_W'(WORD_SMALL) : CNT_W'(WORD_SMALL * BYTES_PER_WORD);
            LIM_MED:   limit_v = wide ? CNT_W'(WORD_MED)   : CNT_W'(MAX_BEATS);
            default:   limit_v = CNT_W'(MAX_BEATS);
        endcase
    end

    // Saturating beat counter, cleared at each tenure start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (beat && cnt_q < CNT_W'(MAX_BEATS))
            cnt_q <= cnt_q + 1'b1;
    end

    assign limit_hit = !limit_sel[1] && (cnt_q >= limit_v);
endmodule

// File: rtl/dma_ack_timer.sv
// Counts cycles that a strobe has waited without acknowledge and raises
// expire in the last allowed cycle. Assumes run stays high per transfer.
module dma_ack_timer #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic expire
);
    localparam int TW = $clog2(TIMEOUT);

    logic [TW-1:0] wait_q;

    // Restart on every acknowledge or whenever no strobe is out.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || ack)
            wait_q <= '0;
        else
            wait_q <= wait_q + 1'b1;
    end

    assign expire = run && !ack && (wait_q == TW'(TIMEOUT - 1));
endmodule

// File: rtl/dma_byte_lane.sv
// Reverses the byte order of a word when swap is set; for 16 bits this
// exchanges the two bytes. Pure combinational; DW must be a multiple of 8.
module dma_byte_lane #(
    parameter int DW = 16
) (
    input  logic          swap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign dout[i*8 +: 8] = swap ? din[(NB-1-i)*8 +: 8] : din[i*8 +: 8];
    end
endmodule

// File: rtl/dma_burst_seq.sv
// Tenure sequencer: request, grant, strobe/acknowledge loop, three-way
// termination, timeout abort and the post-release idle cycle.
// Assumes bus_grant stays high while bus_req is high.
module dma_burst_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_pending,
    input  logic bus_grant,
    input  logic mem_ack,
    input  logic rel_n,
    input  logic limit_hit,
    input  logic ack_expired,
    output logic bus_req,
    output logic mem_strobe,
    output logic burst_start,
    output logic beat_done,
    output logic timeout_abort
);
    import dma_burst_pkg::*;

    bst_t state_q, state_d;
    logic rel_seen_q;
    logic stop_now;

    assign burst_start   = (state_q == ST_REQ) && bus_grant && xfer_pending;
    assign beat_done     = (state_q == ST_XFER) && mem_ack;
    assign timeout_abort = (state_q == ST_XFER) && ack_expired;
    assign stop_now      = !xfer_pending || limit_hit || rel_seen_q || !rel_n;

    // Next-state selection for the tenure.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (xfer_pending) state_d = ST_REQ;
            ST_REQ:  if (bus_grant) state_d = xfer_pending ? ST_XFER : ST_GAP;
            ST_XFER: begin
                if (mem_ack)          state_d = ST_NEXT;
                else if (ack_expired) state_d = ST_GAP;
            end
            ST_NEXT: state_d = stop_now ? ST_GAP : ST_XFER;
            ST_GAP:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remember a release request seen during the tenure.
    always_ff @(posedge clk) begin
        if (!rst_n || burst_start)
            rel_seen_q <= 1'b0;
        else if (!rel_n && (state_q == ST_XFER || state_q == ST_NEXT))
            rel_seen_q <= 1'b1;
    end

    assign bus_req    = (state_q == ST_REQ) || (state_q == ST_XFER) || (state_q == ST_NEXT);
    assign mem_strobe = (state_q == ST_XFER);
endmodule

// File: rtl/dma_burst_master.sv
// Top of the burst bus-master: ties the sequencer, beat limiter, acknowledge
// timer and byte lanes together, and holds the address pointer, latched
// direction/traffic class and the sticky memory-error flag.
// Assumes configuration inputs are stable while bus_req is high.
module dma_burst_master #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int TIMEOUT    = 256,
    parameter int WORD_SMALL = 1,
    parameter int WORD_MED   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_pending,
    input  logic              xfer_dir,
    input  logic              xfer_ctrl,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_wide,
    input  logic [1:0]        cfg_limit,
    input  logic              cfg_swap_data,
    input  logic              cfg_swap_ctrl,
    input  logic              err_clr,
    input  logic              bus_grant,
    input  logic              rel_n,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              bus_req,
    output logic              mem_strobe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_err
);
    localparam int BYTES_PER_WORD = DATA_W / 8;

    logic burst_start, beat_done, timeout_abort;
    logic limit_hit, ack_expired;
    logic [ADDR_W-1:0] addr_q;
    logic dir_q, ctrl_q, err_q, swap_en;

    dma_burst_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_pending (xfer_pending),
        .bus_grant    (bus_grant),
        .mem_ack      (mem_ack),
        .rel_n        (rel_n),
        .limit_hit    (limit_hit),
        .ack_expired  (ack_expired),
        .bus_req      (bus_req),
        .mem_strobe   (mem_strobe),
        .burst_start  (burst_start),
        .beat_done    (beat_done),
        .timeout_abort(timeout_abort)
    );

    dma_beat_limiter #(
        .WORD_SMALL    (WORD_SMALL),
        .WORD_MED      (WORD_MED),
        .BYTES_PER_WORD(BYTES_PER_WORD)
    ) u_lim (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (burst_start),
        .beat     (beat_done),
        .wide     (cfg_wide),
        .limit_sel(cfg_limit),
        .limit_hit(limit_hit)
    );

    dma_ack_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mem_strobe),
        .ack   (mem_ack),
        .expire(ack_expired)
    );

    // Address pointer: load at grant, step per acknowledged transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (burst_start)
            addr_q <= base_addr;
        else if (beat_done)
            addr_q <= addr_q + (cfg_wide ? ADDR_W'(BYTES_PER_WORD) : ADDR_W'(1));
    end

    // Latch direction and traffic class for the tenure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            ctrl_q <= 1'b0;
        end else if (burst_start) begin
            dir_q  <= xfer_dir;
            ctrl_q <= xfer_ctrl;
        end
    end

    // Sticky memory-error flag; a new timeout wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             err_q <= 1'b0;
        else if (timeout_abort) err_q <= 1'b1;
        else if (err_clr)       err_q <= 1'b0;
    end

    assign swap_en = cfg_wide && (ctrl_q ? cfg_swap_ctrl : cfg_swap_data);

    dma_byte_lane #(.DW(DATA_W)) u_wr_lane (
        .swap(swap_en),
        .din (wr_data),
        .dout(mem_wdata)
    );

    dma_byte_lane #(.DW(DATA_W)) u_rd_lane (
        .swap(swap_en),
        .din (mem_rdata),
        .dout(rd_data)
    );

    assign mem_addr = addr_q;
    assign mem_we   = mem_strobe && dir_q;
    assign wr_take  = beat_done && dir_q;
    assign rd_valid = beat_done && !dir_q;
    assign mem_err  = err_q;
endmodule

// File: rtl/dma_burst_master_chk.sv
// Checker for dma_burst_master, bound to every instance. Keeps its own
// wait and beat counters so long windows need no deep $past.
module dma_burst_master_chk #(
    parameter int TIMEOUT    = 256,
    parameter int WORD_SMALL = 1,
    parameter int WORD_MED   = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_pending,
    input logic       cfg_wide,
    input logic [1:0] cfg_limit,
    input logic       err_clr,
    input logic       bus_grant,
    input logic       rel_n,
    input logic       mem_ack,
    input logic       bus_req,
    input logic       mem_strobe,
    input logic       mem_err
);
    localparam int WW = $clog2(TIMEOUT) + 1;

    logic [WW-1:0] wait_c;
    logic [7:0]    beats_c;
    int            lim;
    logic          abort_now;

    // Cycles the current strobe has waited.
    always_ff @(posedge clk) begin
        if (!rst_n || !mem_strobe || mem_ack) wait_c <= '0;
        else                                  wait_c <= wait_c + 1'b1;
    end

    // Acknowledged beats in the current tenure.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_req)                         beats_c <= '0;
        else if (mem_strobe && mem_ack && beats_c != '1) beats_c <= beats_c + 1'b1;
    end

    assign lim = (cfg_limit == 2'd0) ? (cfg_wide ? WORD_SMALL : 2 * WORD_SMALL)
                                     : (cfg_wide ? WORD_MED : 2 * WORD_MED);
    assign abort_now = mem_strobe && !mem_ack && (wait_c == WW'(TIMEOUT - 1));

    a_r1_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_strobe) |-> $past(bus_grant));
    a_r2_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !mem_strobe && $past(mem_strobe && mem_ack) && !xfer_pending) |=> !bus_req);
    a_r3_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_limit[1] |-> (int'(beats_c) <= lim));
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && mem_ack && !rel_n) |=> !mem_strobe ##1 !bus_req);
    a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |-> (wait_c < WW'(TIMEOUT)));
    a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now |=> (!bus_req && !mem_strobe && mem_err));
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_err && !err_clr) |=> mem_err);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !abort_now) |=> !mem_err);
    a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |=> !bus_req);
endmodule

bind dma_burst_master dma_burst_master_chk #(
    .TIMEOUT   (TIMEOUT),
    .WORD_SMALL(WORD_SMALL),
    .WORD_MED  (WORD_MED)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_pending(xfer_pending),
    .cfg_wide    (cfg_wide),
    .cfg_limit   (cfg_limit),
    .err_clr     (err_clr),
    .bus_grant   (bus_grant),
    .rel_n       (rel_n),
    .mem_ack     (mem_ack),
    .bus_req     (bus_req),
    .mem_strobe  (mem_strobe),
    .mem_err     (mem_err)
);

// File: tb/dma_burst_master_bench.sv
module dma_burst_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_pending = 1'b0, xfer_dir = 1'b0, xfer_ctrl = 1'b0;
    logic [15:0] base_addr = '0, wr_data = '0, mem_rdata = '0;
    logic        cfg_wide = 1'b1;
    logic [1:0]  cfg_limit = 2'd2;
    logic        cfg_swap_data = 1'b0, cfg_swap_ctrl = 1'b0, err_clr = 1'b0;
    logic        bus_grant = 1'b0, rel_n = 1'b1, mem_ack = 1'b0;
    logic        bus_req, mem_strobe, mem_we, wr_take, rd_valid, mem_err;
    logic [15:0] mem_addr, mem_wdata, rd_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    dma_burst_master u_dma_burst_master (.*);

    always #4 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(string tag, bit ok, int got, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] xswap(logic [15:0] v, bit en);
        return en ? {v[7:0], v[15:8]} : v;
    endfunction

    function automatic int exp_beats(int n, bit wide, logic [1:0] lim, int rel_at);
        int l, r;
        if (lim[1])           l = 1 << 20;
        else if (lim == 2'd0) l = wide ? 1 : 2;
        else                  l = wide ? 8 : 16;
        r = n;
        if (l < r) r = l;
        if (rel_at > 0 && rel_at < r) r = rel_at;
        return r;
    endfunction

    // One tenure: arbiter and memory models, per-beat and end checks.
    task automatic run_tenure(int n, bit wide, logic [1:0] lim, bit sd, bit sc,
                              bit ctrl, bit dir, int rel_at, string tag);
        int remaining = n, beats = 0, wt = 0, gdel = 0, exp;
        bit started = 0, done = 0, en;
        logic [15:0] base;
        @(negedge clk);
        base = 16'($urandom);
        cfg_wide = wide; cfg_limit = lim; cfg_swap_data = sd; cfg_swap_ctrl = sc;
        xfer_ctrl = ctrl; xfer_dir = dir; base_addr = base;
        wr_data = 16'($urandom); mem_rdata = 16'($urandom);
        rel_n = 1'b1; xfer_pending = 1'b1;
        en = wide && (ctrl ? sc : sd);
        while (!done) begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wr_data = 16'($urandom);
                mem_rdata = 16'($urandom);
                wt = $urandom % 4;
            end
            if (mem_strobe) begin
                if (!started) chk("R1 strobe without grant", bus_grant, bus_grant, 1);
                started = 1;
                if (wt == 0) begin
                    chk("R9 address", mem_addr == base + 16'(beats * (wide ? 2 : 1)), mem_addr,
                        base + 16'(beats * (wide ? 2 : 1)));
                    mem_ack = 1'b1;
                    #1;
                    if (dir) begin
                        chk("R8 write lane", mem_wdata == xswap(wr_data, en), mem_wdata, xswap(wr_data, en));
                        chk("R8 write pop", wr_take && mem_we, wr_take, 1);
                    end else begin
                        chk("R8 read lane", rd_data == xswap(mem_rdata, en), rd_data, xswap(mem_rdata, en));
                        chk("R8 read valid", rd_valid && !mem_we, rd_valid, 1);
                    end
                    remaining--; beats++;
                    xfer_pending = (remaining > 0);
                    if (beats == rel_at) rel_n = 1'b0;
                end else wt--;
            end
            if (started && !bus_req) done = 1;
            if (bus_req) begin
                if (gdel == 0) bus_grant = 1'b1; else gdel--;
            end else begin
                bus_grant = 1'b0;
                gdel = $urandom % 3;
            end
        end
        exp = exp_beats(n, wide, lim, rel_at);
        chk(tag, beats == exp, beats, exp);
        chk("R5 no error on normal end", !mem_err, mem_err, 0);
        @(negedge clk);
        chk("R7 idle gap", !bus_req, bus_req, 0);
        xfer_pending = 1'b0; rel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", !bus_req && !mem_strobe && !mem_err && !wr_take && !rd_valid,
            {bus_req, mem_strobe, mem_err, wr_take, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed corner cases.
        run_tenure(10, 1, 2'd0, 0, 0, 0, 1, 0, "R3 wide small limit");
        run_tenure(10, 0, 2'd0, 1, 1, 0, 0, 0, "R3 byte small limit");
        run_tenure(20, 1, 2'd1, 1, 0, 0, 1, 0, "R3 wide medium limit");
        run_tenure(20, 0, 2'd1, 0, 1, 1, 0, 0, "R3 byte medium limit");
        run_tenure(20, 1, 2'd3, 0, 1, 1, 0, 0, "R3 unlimited");
        run_tenure(5,  1, 2'd1, 0, 0, 0, 0, 0, "R2 source empty");
        run_tenure(20, 1, 2'd2, 1, 0, 0, 1, 3, "R4 release pin");
        run_tenure(20, 0, 2'd2, 0, 0, 1, 1, 1, "R4 release first beat");

        // Random tenures.
        for (int i = 0; i < 14; i++) begin
            run_tenure(1 + $urandom % 24, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), $urandom % 2 ? 0 : 1 + $urandom % 10,
                       "R2 R3 R4 random tenure beats");
        end

        // Timeout: memory never answers.
        begin
            int hi = 0;
            @(negedge clk);
            xfer_pending = 1'b1; cfg_limit = 2'd2;
            while (!mem_strobe) begin
                @(negedge clk);
                bus_grant = bus_req;
            end
            while (mem_strobe) begin
                hi++;
                @(negedge clk);
            end
            chk("R5 strobe cycles before abort", hi == 256, hi, 256);
            chk("R5 bus released", !bus_req, bus_req, 0);
            chk("R5 error raised", mem_err, mem_err, 1);
            xfer_pending = 1'b0; bus_grant = 1'b0;
            repeat (4) @(negedge clk);
            chk("R6 error sticky", mem_err, mem_err, 1);
            err_clr = 1'b1;
            @(negedge clk);
            err_clr = 1'b0;
            chk("R6 error cleared", !mem_err, mem_err, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        bad++; total++;
        $display("FAIL watchdog got=%0d exp=0", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule